// File: doc/BRIEF.md
# I/O Port Address Sequencer

This block sits between a small processor's instruction decoder and its data I/O space of 256 ports. For every port access it forms the 8-bit port address and raises a single-cycle read or write strobe. The decoder supplies the kind of access (read, write or none), the addressing mode, an 8-bit register operand and a 5-bit immediate field. The address and strobes appear in the same cycle as the access. The block remembers the last address it issued.

There are three addressing modes. Indirect mode reaches any of the 256 ports through the register operand. Direct mode puts three one bits in front of the immediate, so it reaches ports 224 to 255. A push to the external data stack is a direct write to port 255, and a pop is a direct read from port 255. Sequential mode addresses the port one above the last one used, so multi-byte values can be read or written with a run of accesses that each carry no address.

Top module: `portseq_top`

## Requirements
- R1: While reset is high, and after it is released, both strobes are low and the remembered address is 0. The first sequential access after reset therefore targets port 1.
- R2: An access with mode code 2'b00 (indirect) drives portAddress with regOperand.
- R3: An access with mode code 2'b10 or 2'b11 (mode bit 1 set, direct) drives portAddress with {3'b111, immPort}. Immediate 31 gives port 255, the data stack port.
- R4: An access with mode code 2'b01 (sequential) drives portAddress with the remembered address plus one.
- R5: When the remembered address is 255, a sequential access wraps to port 0.
- R6: Every read or write access, in any mode, replaces the remembered address with the address issued in that cycle.
- R7: Access kind 2'b01 is a write: portWrite is 1 and portRead is 0. Kind 2'b10 is a read: portRead is 1 and portWrite is 0. Kind 2'b00 (idle) and 2'b11 (reserved) keep both strobes low. The two strobes are never high together.
- R8: In an idle or reserved cycle, portAddress shows the remembered address and the remembered address does not change. Mode, regOperand and immPort have no effect in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| accKind | input | 2 | Access kind: 00 idle, 01 write, 10 read, 11 reserved (treated as idle) |
| accMode | input | 2 | Addressing mode: 00 indirect, 01 sequential, 1x direct |
| regOperand | input | 8 | Register value used as the indirect address |
| immPort | input | 5 | Immediate field used for direct addressing |
| portAddress | output | 8 | Port address of the current access |
| portRead | output | 1 | Read strobe, one cycle per read access |
| portWrite | output | 1 | Write strobe, one cycle per write access |

## Verification
Random runs mix all three modes with reads, writes and idle cycles. Because every sequential result depends on whichever access came before it, these runs show whether the remembered address is updated by every mode and every kind, and left alone otherwise. Directed sequences cover several cases: a sequential access straight after reset, which tells a cleared register from an uncleared one; an indirect access to 255 followed by a sequential one, which exposes a missing wrap; direct pushes and pops on port 255; and idle or reserved cycles carrying busy-looking operands, which show whether those operands leak into the address or the stored state.

// File: rtl/portseq_pkg.sv
package portseq_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_DIR  = 2'b10,
    MODE_DIR2 = 2'b11
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdStb;
    logic wrStb;
    logic selInd;
    logic selSeq;
    logic selDir;
    logic capture;
  } seqCtl_t;

endpackage

// File: rtl/portseq_ctrl.sv
module portseq_ctrl
  import portseq_pkg::*;
(
  input  accKind_e kind,
  input  accMode_e mode,
  output seqCtl_t  ctl
);

  logic busy;

  always_comb begin
    busy = (kind == ACC_WRITE) || (kind == ACC_READ);
    ctl = '0;
    ctl.rdStb   = (kind == ACC_READ);
    ctl.wrStb   = (kind == ACC_WRITE);
    ctl.capture = busy;
    if (busy) begin
      unique case (mode)
        MODE_IND:            ctl.selInd = 1'b1;
        MODE_SEQ:            ctl.selSeq = 1'b1;
        MODE_DIR, MODE_DIR2: ctl.selDir = 1'b1;
        default:             ctl.selInd = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/portseq_dpath.sv
module portseq_dpath
  import portseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] regOperand,
  input  logic [IMM_W-1:0]  immPort,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int PRE_W = ADDR_W - IMM_W;
  localparam logic [PRE_W-1:0]  DIR_PREFIX = '1;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] dirAddr;

  assign seqAddr = lastAddr + ONE;   // wraps at the top of the space
  assign dirAddr = {DIR_PREFIX, immPort};

  always_comb begin
    if (ctl.selInd)      addrOut = regOperand;
    else if (ctl.selSeq) addrOut = seqAddr;
    else if (ctl.selDir) addrOut = dirAddr;
    else                 addrOut = lastAddr;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              lastAddr <= '0;
    else if (ctl.capture) lastAddr <= addrOut;
  end

endmodule

// File: rtl/portseq_top.sv
module portseq_top
  import portseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accMode,
  input  logic [ADDR_W-1:0] regOperand,
  input  logic [IMM_W-1:0]  immPort,
  output logic [ADDR_W-1:0] portAddress,
  output logic              portRead,
  output logic              portWrite
);

  seqCtl_t ctl;

  portseq_ctrl u_ctrl (
    .kind (accKind_e'(accKind)),
    .mode (accMode_e'(accMode)),
    .ctl  (ctl)
  );

  portseq_dpath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .regOperand (regOperand),
    .immPort    (immPort),
    .addrOut    (portAddress)
  );

  assign portRead  = ctl.rdStb;
  assign portWrite = ctl.wrStb;

endmodule

// File: rtl/portseq_checker.sv
module portseq_checker #(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        accKind,
  input logic [1:0]        accMode,
  input logic [ADDR_W-1:0] regOperand,
  input logic [IMM_W-1:0]  immPort,
  input logic [ADDR_W-1:0] portAddress,
  input logic              portRead,
  input logic              portWrite
);

  localparam int PRE_W = ADDR_W - IMM_W;

  logic pastValid;
  logic busy;

  assign busy = (accKind == 2'b01) || (accKind == 2'b10);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pastValid <= 1'b0;
    else     pastValid <= 1'b1;
  end

  // R7: strobes never together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(portRead && portWrite));

  // R7: no strobe without an access
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!portRead && !portWrite));

  // R2: indirect address follows the register operand
  a_r2_indirect: assert property (@(posedge clk) disable iff (rst)
    (busy && accMode == 2'b00) |-> (portAddress == regOperand));

  // R3: direct address lands in the top ports
  a_r3_direct: assert property (@(posedge clk) disable iff (rst)
    (busy && accMode[1]) |->
      (portAddress == {{PRE_W{1'b1}}, immPort}));

  // R4, R5, R6: sequential is one above whatever was shown last cycle
  a_r4_sequential: assert property (@(posedge clk) disable iff (rst)
    (pastValid && busy && accMode == 2'b01) |->
      (portAddress == ADDR_W'($past(portAddress) + 1)));

  // R8: idle cycles hold the address
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !busy) |-> (portAddress == $past(portAddress)));

endmodule

bind portseq_top portseq_checker #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .accKind     (accKind),
  .accMode     (accMode),
  .regOperand  (regOperand),
  .immPort     (immPort),
  .portAddress (portAddress),
  .portRead    (portRead),
  .portWrite   (portWrite)
);

// File: tb/portseq_tb.sv
`timescale 1ns/1ps
module portseq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] accKind = 2'b00;
  logic [1:0] accMode = 2'b00;
  logic [7:0] regOperand = 8'h00;
  logic [4:0] immPort = 5'h00;
  logic [7:0] portAddress;
  logic       portRead;
  logic       portWrite;

  int checks = 0;
  int errors = 0;
  logic [7:0] lastExp = 8'h00;
  bit finished = 0;

  always #10 clk = ~clk;

  portseq_top dut_i (
    .clk(clk), .rst(rst), .accKind(accKind), .accMode(accMode),
    .regOperand(regOperand), .immPort(immPort),
    .portAddress(portAddress), .portRead(portRead), .portWrite(portWrite)
  );

  function automatic bit isBusy(input logic [1:0] k);
    return (k == 2'b01) || (k == 2'b10);
  endfunction

  function automatic logic [7:0] expAddr(input logic [1:0] k, input logic [1:0] m,
                                         input logic [7:0] r, input logic [4:0] i,
                                         input logic [7:0] last);
    if (!isBusy(k))     return last;
    if (m == 2'b00)     return r;
    if (m == 2'b01)     return last + 8'd1;
    return {3'b111, i};
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle, check the outputs mid-cycle, update the model at the edge
  task automatic step(input logic [1:0] k, input logic [1:0] m,
                      input logic [7:0] r, input logic [4:0] i, input string tag);
    logic [7:0] ea;
    @(negedge clk);
    accKind = k; accMode = m; regOperand = r; immPort = i;
    #2;
    ea = expAddr(k, m, r, i, lastExp);
    checkVal(tag, "portAddress", portAddress, ea);
    checkVal("R7", "portRead", {7'd0, portRead}, {7'd0, k == 2'b10});
    checkVal("R7", "portWrite", {7'd0, portWrite}, {7'd0, k == 2'b01});
    @(posedge clk);
    if (isBusy(k)) lastExp = ea;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] k;
    logic [1:0] m;
    string tag;
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R1", "portRead in reset", {7'd0, portRead}, 8'd0);
    checkVal("R1", "portWrite in reset", {7'd0, portWrite}, 8'd0);
    checkVal("R1", "portAddress in reset", portAddress, 8'd0);
    rst = 1'b0;
    lastExp = 8'h00;
    // R1 / R4: first sequential read after reset goes to port 1
    step(2'b10, 2'b01, 8'hAA, 5'h03, "R1");
    step(2'b01, 2'b01, 8'h55, 5'h07, "R4");
    // R2 then R5: indirect to 255, sequential wraps to 0
    step(2'b01, 2'b00, 8'hFF, 5'h00, "R2");
    step(2'b10, 2'b01, 8'h12, 5'h1F, "R5");
    // R3: push and pop on the stack port 255, alternate direct code
    step(2'b01, 2'b10, 8'h00, 5'h1F, "R3");
    step(2'b10, 2'b11, 8'h00, 5'h1F, "R3");
    step(2'b10, 2'b01, 8'h00, 5'h00, "R5");
    step(2'b01, 2'b10, 8'h00, 5'h00, "R3");
    // R6: sequential after a direct access continues from 224
    step(2'b01, 2'b01, 8'h00, 5'h00, "R6");
    // R8: idle and reserved cycles with busy-looking operands
    step(2'b00, 2'b00, 8'h3C, 5'h11, "R8");
    step(2'b11, 2'b10, 8'h99, 5'h05, "R8");
    step(2'b11, 2'b01, 8'h99, 5'h05, "R8");
    step(2'b10, 2'b01, 8'h00, 5'h00, "R8");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      k = 2'($urandom_range(0, 3));
      m = 2'($urandom_range(0, 3));
      if (!isBusy(k))       tag = "R8";
      else if (m == 2'b00)  tag = "R2";
      else if (m == 2'b01)  tag = (lastExp == 8'hFF) ? "R5" : "R6";
      else                  tag = "R3";
      step(k, m, 8'($urandom), 5'($urandom), tag);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule